// File: doc/BRIEF.md
# Context-Tagged Address Translation Cache

This block is a small, fully associative cache of recently resolved translations from virtual page numbers to physical page numbers. It sits in front of the page-table walker: every load, store and instruction fetch presents its virtual page here first. Only a miss needs a walk. Each stored translation carries two tags, a process-context identifier and a virtual-machine identifier. Translations that belong to different processes and different guests can therefore live side by side, and a context switch does not have to empty the cache.

A lookup is resolved combinationally in the cycle it is presented. It returns a hit flag, the physical page and a permission fault flag. The fault flag is computed from read, write and execute bits stored with the entry. The walker installs its results through a fill port. Two maintenance inputs invalidate either every entry or only the entries of one process within one guest. When the cache is full, a rotating pointer picks the entry to replace.

Top module: `tagged_tlb`

## Requirements
- R1: With `lk_req` high, `lk_hit` is 1 in the same cycle exactly when a valid entry has the same virtual page, process ID and VM ID as the lookup. VM ID 0, reserved for the hypervisor, is matched like any other value, so its entries never hit a guest lookup. With `lk_req` low, `lk_hit` is 0.
- R2: On a miss, `lk_hit`, `lk_fault` and `lk_ppn` are all 0. On a hit, `lk_ppn` is the physical page stored in the matching entry.
- R3: Access encodings are 0 = load, 1 = store, 2 = fetch and 3 = reserved. Permission bits are bit 0 = read, bit 1 = write and bit 2 = execute. On a hit, `lk_fault` is 1 when the stored bit for the access type is clear, and it is always 1 for code 3. `lk_fault` is never 1 without `lk_hit`.
- R4: A fill whose key is not already present writes the lowest-numbered invalid entry. The new translation can be looked up from the next cycle on.
- R5: When all entries are valid, a fill with a new key replaces the entry chosen by a rotating pointer. The pointer is 0 after reset and advances by one, wrapping at the entry count, only on fills that use it.
- R6: A fill whose virtual page, process ID and VM ID match a valid entry overwrites that entry in place. No duplicate is created and no other entry is displaced.
- R7: `inv_all` invalidates every entry at the next clock edge.
- R8: `inv_ctx` invalidates only the entries whose process ID equals `inv_pid` and whose VM ID equals `inv_vmid`. All other entries keep hitting.
- R9: When a flush and a fill occur in the same cycle, the flush is applied first. The filled translation survives, and an entry freed by the flush can receive the fill.
- R10: After reset, no lookup hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 36 | Virtual page number to translate |
| lk_pid | input | 12 | Current process-context ID |
| lk_vmid | input | 8 | Current VM ID |
| lk_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 reserved |
| lk_hit | output | 1 | Translation found |
| lk_ppn | output | 36 | Physical page number (0 on a miss) |
| lk_fault | output | 1 | Hit, but the access is not permitted |
| fl_en | input | 1 | Install a translation |
| fl_vpn | input | 36 | Virtual page of the fill |
| fl_pid | input | 12 | Process ID of the fill |
| fl_vmid | input | 8 | VM ID of the fill |
| fl_ppn | input | 36 | Physical page of the fill |
| fl_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| inv_all | input | 1 | Invalidate all entries |
| inv_ctx | input | 1 | Invalidate entries of one process in one VM |
| inv_pid | input | 12 | Process ID selected by `inv_ctx` |
| inv_vmid | input | 8 | VM ID selected by `inv_ctx` |

## Verification
The hardest case to reach from the ports is a fill that arrives in the same cycle as a flush. This is hardest when the cache is full and the fill key matches an entry that the flush is about to remove, because the choice between overwrite, free slot and rotating victim then depends on the state after the flush. Directed steps fill all sixteen entries to force the rotating victim. They then combine a context flush with a fill of a key from the same context, and combine a full flush with a fill. The random phase draws its keys from a small pool of pages, process IDs and VM IDs, with VM 0 included, so overwrites, evictions and flush-plus-fill collisions recur throughout.

// File: rtl/tagged_tlb_pkg.sv
package tagged_tlb_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int PERM_R = 0;
  localparam int PERM_W = 1;
  localparam int PERM_X = 2;

  // Does the permission triple grant this access type?
  function automatic logic perm_allows(logic [2:0] perm, acc_e acc);
    logic ok;
    case (acc)
      ACC_LOAD:  ok = perm[PERM_R];
      ACC_STORE: ok = perm[PERM_W];
      ACC_FETCH: ok = perm[PERM_X];
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/tlb_tag_match.sv
module tlb_tag_match #(
  parameter int N      = 16,
  parameter int VPN_W  = 36,
  parameter int PID_W  = 12,
  parameter int VMID_W = 8
) (
  input  logic [N-1:0]             mask,
  input  logic [N-1:0][VPN_W-1:0]  ent_vpn,
  input  logic [N-1:0][PID_W-1:0]  ent_pid,
  input  logic [N-1:0][VMID_W-1:0] ent_vmid,
  input  logic [VPN_W-1:0]         key_vpn,
  input  logic [PID_W-1:0]         key_pid,
  input  logic [VMID_W-1:0]        key_vmid,
  output logic [N-1:0]             match
);

  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic vpn_eq, pid_eq, vmid_eq;
    assign vpn_eq   = (ent_vpn[i]  == key_vpn);
    assign pid_eq   = (ent_pid[i]  == key_pid);
    assign vmid_eq  = (ent_vmid[i] == key_vmid);
    assign match[i] = mask[i] & vpn_eq & pid_eq & vmid_eq;
  end

endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int N      = 16,
  parameter int VPN_W  = 36,
  parameter int PPN_W  = 36,
  parameter int PID_W  = 12,
  parameter int VMID_W = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     inv_all,
  input  logic                     inv_ctx,
  input  logic [PID_W-1:0]         inv_pid,
  input  logic [VMID_W-1:0]        inv_vmid,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [VPN_W-1:0]         wr_vpn,
  input  logic [PID_W-1:0]         wr_pid,
  input  logic [VMID_W-1:0]        wr_vmid,
  input  logic [PPN_W-1:0]         wr_ppn,
  input  logic [2:0]               wr_perm,
  output logic [N-1:0]             vld,
  output logic [N-1:0]             kept,
  output logic [N-1:0][VPN_W-1:0]  ent_vpn,
  output logic [N-1:0][PPN_W-1:0]  ent_ppn,
  output logic [N-1:0][PID_W-1:0]  ent_pid,
  output logic [N-1:0][VMID_W-1:0] ent_vmid,
  output logic [N-1:0][2:0]        ent_perm
);

  logic [N-1:0] wr_sel;

  // Survivors of this cycle's flush requests; the fill sees only these.
  for (genvar i = 0; i < N; i++) begin : g_keep
    logic ctx_hit;
    assign ctx_hit   = inv_ctx && (ent_pid[i] == inv_pid) && (ent_vmid[i] == inv_vmid);
    assign kept[i]   = vld[i] & ~inv_all & ~ctx_hit;
    assign wr_sel[i] = wr_en && (wr_idx == IDX_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else        vld <= kept | wr_sel;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_vpn[wr_idx]  <= wr_vpn;
      ent_ppn[wr_idx]  <= wr_ppn;
      ent_pid[wr_idx]  <= wr_pid;
      ent_vmid[wr_idx] <= wr_vmid;
      ent_perm[wr_idx] <= wr_perm;
    end
  end

endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill,
  input  logic [N-1:0]     kept,
  input  logic [N-1:0]     same_key,
  output logic [IDX_W-1:0] wr_idx,
  output logic             use_rr
);

  logic [IDX_W-1:0] rr_ptr;

  function automatic logic [IDX_W-1:0] onehot_idx(logic [N-1:0] v);
    logic [IDX_W-1:0] r = '0;
    for (int i = 0; i < N; i++) if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] lowest_free(logic [N-1:0] v);
    logic [IDX_W-1:0] r = '0;
    for (int i = N - 1; i >= 0; i--) if (!v[i]) r = IDX_W'(i);
    return r;
  endfunction

  logic any_same, all_full;
  assign any_same = |same_key;
  assign all_full = &kept;
  assign use_rr   = fill && !any_same && all_full;

  always_comb begin
    if (any_same)      wr_idx = onehot_idx(same_key);
    else if (!all_full) wr_idx = lowest_free(kept);
    else               wr_idx = rr_ptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rr_ptr <= '0;
    else if (use_rr) rr_ptr <= (rr_ptr == IDX_W'(N - 1)) ? '0 : rr_ptr + 1'b1;
  end

endmodule

// File: rtl/tagged_tlb.sv
module tagged_tlb
  import tagged_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 36,
  parameter int PPN_W   = 36,
  parameter int PID_W   = 12,
  parameter int VMID_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [PID_W-1:0]  lk_pid,
  input  logic [VMID_W-1:0] lk_vmid,
  input  logic [1:0]        lk_acc,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic              lk_fault,
  input  logic              fl_en,
  input  logic [VPN_W-1:0]  fl_vpn,
  input  logic [PID_W-1:0]  fl_pid,
  input  logic [VMID_W-1:0] fl_vmid,
  input  logic [PPN_W-1:0]  fl_ppn,
  input  logic [2:0]        fl_perm,
  input  logic              inv_all,
  input  logic              inv_ctx,
  input  logic [PID_W-1:0]  inv_pid,
  input  logic [VMID_W-1:0] inv_vmid
);

  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]             vld, kept, lk_match, fill_hit;
  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn;
  logic [ENTRIES-1:0][PPN_W-1:0]  ent_ppn;
  logic [ENTRIES-1:0][PID_W-1:0]  ent_pid;
  logic [ENTRIES-1:0][VMID_W-1:0] ent_vmid;
  logic [ENTRIES-1:0][2:0]        ent_perm;
  logic [IDX_W-1:0]               wr_idx, hit_idx;
  logic                           use_rr;

  function automatic logic [IDX_W-1:0] enc_idx(logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r = '0;
    for (int i = 0; i < ENTRIES; i++) if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  tlb_entry_store #(
    .N(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .PID_W(PID_W), .VMID_W(VMID_W)
  ) u_store (
    .clk, .rst_n,
    .inv_all, .inv_ctx, .inv_pid, .inv_vmid,
    .wr_en(fl_en), .wr_idx,
    .wr_vpn(fl_vpn), .wr_pid(fl_pid), .wr_vmid(fl_vmid),
    .wr_ppn(fl_ppn), .wr_perm(fl_perm),
    .vld, .kept, .ent_vpn, .ent_ppn, .ent_pid, .ent_vmid, .ent_perm
  );

  // Lookup path: compares against the registered valid bits.
  tlb_tag_match #(
    .N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W), .VMID_W(VMID_W)
  ) u_lk_match (
    .mask(vld), .ent_vpn, .ent_pid, .ent_vmid,
    .key_vpn(lk_vpn), .key_pid(lk_pid), .key_vmid(lk_vmid),
    .match(lk_match)
  );

  // Fill path: compares against post-flush survivors (flush before fill).
  tlb_tag_match #(
    .N(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W), .VMID_W(VMID_W)
  ) u_fl_match (
    .mask(kept), .ent_vpn, .ent_pid, .ent_vmid,
    .key_vpn(fl_vpn), .key_pid(fl_pid), .key_vmid(fl_vmid),
    .match(fill_hit)
  );

  tlb_victim_pick #(.N(ENTRIES)) u_victim (
    .clk, .rst_n, .fill(fl_en), .kept, .same_key(fill_hit),
    .wr_idx, .use_rr
  );

  assign hit_idx  = enc_idx(lk_match);
  assign lk_hit   = lk_req && (|lk_match);
  assign lk_ppn   = lk_hit ? ent_ppn[hit_idx] : '0;
  assign lk_fault = lk_hit && !perm_allows(ent_perm[hit_idx], acc_e'(lk_acc));

endmodule

// File: rtl/tagged_tlb_chk.sv
module tagged_tlb_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] vld,
  input logic [N-1:0] lk_match,
  input logic [N-1:0] fill_hit,
  input logic         lk_hit,
  input logic         lk_fault,
  input logic         ppn_any,
  input logic         fl_en,
  input logic         inv_all,
  input logic         inv_ctx
);

  assert_single_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));

  assert_fault_only_on_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> lk_hit);

  assert_miss_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (!ppn_any && !lk_fault));

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all && !fl_en) |=> (vld == '0));

  assert_flush_then_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all && fl_en) |=> ($countones(vld) == 1));

  assert_new_fill_adds_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_en && !inv_all && !inv_ctx && !(&vld) && !(|fill_hit))
      |=> ($countones(vld) == $countones($past(vld)) + 1));

  assert_ctx_flush_shrinks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_ctx && !inv_all && !fl_en) |=> ($countones(vld) <= $countones($past(vld))));

endmodule

bind tagged_tlb tagged_tlb_chk #(.N(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .vld(vld), .lk_match(lk_match), .fill_hit(fill_hit),
  .lk_hit(lk_hit), .lk_fault(lk_fault), .ppn_any(|lk_ppn),
  .fl_en(fl_en), .inv_all(inv_all), .inv_ctx(inv_ctx)
);

// File: tb/tagged_tlb_tb.sv
module tagged_tlb_tb;

  localparam int NE = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        lk_req = 0;
  logic [35:0] lk_vpn = 0;
  logic [11:0] lk_pid = 0;
  logic [7:0]  lk_vmid = 0;
  logic [1:0]  lk_acc = 0;
  logic        lk_hit, lk_fault;
  logic [35:0] lk_ppn;
  logic        fl_en = 0;
  logic [35:0] fl_vpn = 0;
  logic [11:0] fl_pid = 0;
  logic [7:0]  fl_vmid = 0;
  logic [35:0] fl_ppn = 0;
  logic [2:0]  fl_perm = 0;
  logic        inv_all = 0, inv_ctx = 0;
  logic [11:0] inv_pid = 0;
  logic [7:0]  inv_vmid = 0;

  tagged_tlb u_dut (.*);

  // Reference state built from the requirements
  bit          m_vld [NE];
  logic [35:0] m_vpn [NE];
  logic [35:0] m_ppn [NE];
  logic [11:0] m_pid [NE];
  logic [7:0]  m_vmid[NE];
  logic [2:0]  m_perm[NE];
  int          m_rr;
  int          n_chk = 0, n_bad = 0;

  function automatic int m_find(logic [35:0] v, logic [11:0] p, logic [7:0] m);
    for (int i = 0; i < NE; i++)
      if (m_vld[i] && m_vpn[i] == v && m_pid[i] == p && m_vmid[i] == m) return i;
    return -1;
  endfunction

  function automatic bit m_ok(logic [2:0] perm, logic [1:0] acc);
    if (acc == 2'd3) return 1'b0;
    return perm[acc];
  endfunction

  function automatic logic [35:0] rnd36();
    return {$urandom(), $urandom()} & 36'hF_FFFF_FFFF;
  endfunction

  task automatic m_update();
    int idx;
    for (int i = 0; i < NE; i++)
      if (inv_all || (inv_ctx && m_pid[i] == inv_pid && m_vmid[i] == inv_vmid)) m_vld[i] = 0;
    if (fl_en) begin
      idx = m_find(fl_vpn, fl_pid, fl_vmid);
      if (idx < 0)
        for (int i = NE - 1; i >= 0; i--) if (!m_vld[i]) idx = i;
      if (idx < 0) begin
        idx = m_rr;
        m_rr = (m_rr + 1) % NE;
      end
      m_vld[idx] = 1; m_vpn[idx] = fl_vpn; m_ppn[idx] = fl_ppn;
      m_pid[idx] = fl_pid; m_vmid[idx] = fl_vmid; m_perm[idx] = fl_perm;
    end
  endtask

  // Check the lookup outputs for the inputs now applied, then advance one cycle.
  task automatic tick(string tag);
    int idx;
    bit e_hit, e_flt;
    logic [35:0] e_ppn;
    string t;
    #1;
    idx   = lk_req ? m_find(lk_vpn, lk_pid, lk_vmid) : -1;
    e_hit = (idx >= 0);
    e_ppn = e_hit ? m_ppn[idx] : 36'd0;
    e_flt = e_hit && !m_ok(m_perm[idx], lk_acc);
    t = tag;
    if (t == "") t = e_hit ? (e_flt ? "R3" : "R1") : "R2";
    n_chk++;
    if (lk_hit !== e_hit || lk_ppn !== e_ppn || lk_fault !== e_flt) begin
      n_bad++;
      $display("FAIL %s: hit/ppn/fault got %b/%h/%b expected %b/%h/%b",
               t, lk_hit, lk_ppn, lk_fault, e_hit, e_ppn, e_flt);
    end
    @(posedge clk);
    m_update();
    @(negedge clk);
  endtask

  task automatic idle();
    lk_req = 0; fl_en = 0; inv_all = 0; inv_ctx = 0;
  endtask

  task automatic fill(logic [35:0] v, logic [11:0] p, logic [7:0] m,
                      logic [35:0] pp, logic [2:0] pm);
    fl_en = 1; fl_vpn = v; fl_pid = p; fl_vmid = m; fl_ppn = pp; fl_perm = pm;
  endtask

  task automatic look(logic [35:0] v, logic [11:0] p, logic [7:0] m, logic [1:0] a);
    lk_req = 1; lk_vpn = v; lk_pid = p; lk_vmid = m; lk_acc = a;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20417));
    for (int i = 0; i < NE; i++) m_vld[i] = 0;
    m_rr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R10: empty after reset
    idle(); look(36'd100, 12'd5, 8'd1, 2'd0); tick("R10");

    // R4: fill all sixteen slots, lowest free first
    for (int i = 0; i < NE; i++) begin
      idle(); fill(36'd100 + 36'(i), 12'd5, 8'd1, rnd36(), 3'b111); tick("R4");
    end
    for (int i = 0; i < NE; i++) begin
      idle(); look(36'd100 + 36'(i), 12'd5, 8'd1, 2'(i % 3)); tick("R4");
    end

    // R5: rotating victim starts at slot 0, then slot 1
    idle(); fill(36'd200, 12'd5, 8'd1, rnd36(), 3'b111); tick("R5");
    idle(); look(36'd100, 12'd5, 8'd1, 2'd0); tick("R5");
    idle(); fill(36'd201, 12'd5, 8'd1, rnd36(), 3'b111); tick("R5");
    idle(); look(36'd101, 12'd5, 8'd1, 2'd0); tick("R5");
    idle(); look(36'd102, 12'd5, 8'd1, 2'd0); tick("R5");

    // R6: overwrite in place, nothing else displaced
    idle(); fill(36'd105, 12'd5, 8'd1, 36'h9_0000_0005, 3'b001); tick("R6");
    idle(); look(36'd105, 12'd5, 8'd1, 2'd0); tick("R6");
    idle(); look(36'd106, 12'd5, 8'd1, 2'd0); tick("R6");
    idle(); look(36'd102, 12'd5, 8'd1, 2'd0); tick("R6");

    // R3: permission triple 001 against each access type
    for (int a = 0; a < 4; a++) begin
      idle(); look(36'd105, 12'd5, 8'd1, 2'(a)); tick("R3");
    end

    // R1: hypervisor VM 0 entry does not hit a guest lookup
    idle(); fill(36'd300, 12'd5, 8'd0, rnd36(), 3'b101); tick("R1");
    idle(); look(36'd300, 12'd5, 8'd1, 2'd2); tick("R1");
    idle(); look(36'd300, 12'd5, 8'd0, 2'd2); tick("R1");
    idle(); look(36'd300, 12'd6, 8'd0, 2'd2); tick("R1");

    // R8: context flush of pid 5 / VM 0 leaves VM 1 entries
    idle(); inv_ctx = 1; inv_pid = 12'd5; inv_vmid = 8'd0; tick("R8");
    idle(); look(36'd300, 12'd5, 8'd0, 2'd0); tick("R8");
    idle(); look(36'd200, 12'd5, 8'd1, 2'd0); tick("R8");

    // R9: context flush plus fill of a key from the flushed context
    idle(); inv_ctx = 1; inv_pid = 12'd5; inv_vmid = 8'd1;
    fill(36'd200, 12'd5, 8'd1, 36'h1_2345_6789, 3'b010); tick("R9");
    idle(); look(36'd200, 12'd5, 8'd1, 2'd1); tick("R9");
    idle(); look(36'd201, 12'd5, 8'd1, 2'd1); tick("R9");

    // R7 and R9: full flush with a fill in the same cycle
    idle(); fill(36'd400, 12'd7, 8'd2, rnd36(), 3'b100); tick("R9");
    idle(); inv_all = 1; fill(36'd401, 12'd7, 8'd2, 36'hA_BCDE_F012, 3'b100); tick("R9");
    idle(); look(36'd401, 12'd7, 8'd2, 2'd2); tick("R9");
    idle(); look(36'd400, 12'd7, 8'd2, 2'd2); tick("R7");
    idle(); inv_all = 1; tick("R7");
    idle(); look(36'd401, 12'd7, 8'd2, 2'd2); tick("R7");

    // Random phase over a small key pool
    for (int k = 0; k < 3000; k++) begin
      idle();
      lk_req  = ($urandom_range(0, 9) != 0);
      lk_vpn  = 36'($urandom_range(0, 23));
      lk_pid  = 12'($urandom_range(0, 3));
      lk_vmid = 8'($urandom_range(0, 2));
      lk_acc  = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 9) < 4)
        fill(36'($urandom_range(0, 23)), 12'($urandom_range(0, 3)),
             8'($urandom_range(0, 2)), rnd36(), 3'($urandom_range(0, 7)));
      inv_all  = ($urandom_range(0, 99) < 2);
      inv_ctx  = ($urandom_range(0, 99) < 5);
      inv_pid  = 12'($urandom_range(0, 3));
      inv_vmid = 8'($urandom_range(0, 2));
      tick("");
    end

    idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule